// File: doc/BRIEF.md
# Host Command and Status Mailbox

This block links a host bus to an embedded sub-controller through two byte-wide mailboxes. The host drives an active-low enable, a select line that chooses between the mailboxes and the bulk data port, and active-low read and write strobes. The block brings these lines into the system clock domain and decodes them into one of four operations: command write, status read, data write or data read. Each operation takes effect once for each strobe assertion.

Command bytes go into a twelve-entry queue that the sub-controller drains. A sticky interrupt tells the sub-controller that commands are waiting. Status bytes come back through a second twelve-entry queue, and an active-low flag tells the host that a status byte is ready. The bulk data path is not stored here: a data write or data read only produces a one-clock strobe toward the external data port. If the sub-controller has set its break control, a command write also aborts the transfer in progress. The abort empties the status queue and pulses an abort output.

Top module: `hostmbx_top`

## Requirements
- R1: With `host_en_n`=0 and `host_sel`=0, a falling `host_wr_n` while `host_rd_n`=1 pushes `host_wdata` into the command queue. The sub-controller sees bytes on `sub_cmd_data` in arrival order, and each `sub_cmd_pop` pulse removes the head byte.
- R2: With `host_en_n`=0 and `host_sel`=0, a falling `host_rd_n` while `host_wr_n`=1 pops the head of the status queue onto `host_rdata`. Bytes come out in the order `sub_stat_push` loaded them.
- R3: With `host_en_n`=0 and `host_sel`=1, the same write pattern gives a single one-clock `data_wr_stb` and the same read pattern gives a single one-clock `data_rd_stb`. Neither queue changes. The two strobes are never high together.
- R4: While `host_en_n`=1, strobe activity has no effect on the queues, the interrupt or the strobes.
- R5: The command queue holds 12 bytes. A command write into a full queue is dropped, and the stored bytes and their order are unchanged.
- R6: `cmd_irq` goes high after an accepted command write. It stays high until the sub-controller pops the last byte.
- R7: A status read of an empty status queue returns 0x00 on `host_rdata` and leaves the queue unchanged.
- R8: `stat_avail_n` is low exactly while the status queue holds at least one byte. The status queue holds 12 bytes, and a `sub_stat_push` into a full queue is dropped.
- R9: A command write while `brk_set`=1 empties the status queue and raises `abort_pulse` for exactly one clock. The command byte is still queued, and the command queue is not flushed.
- R10: A strobe held low for many cycles yields exactly one operation. The result is registered by the third rising clock edge after the strobe falls.
- R11: After reset, `cmd_irq`=0, `stat_avail_n`=1, `abort_pulse`=0, both data strobes are 0 and `host_rdata`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en_n | input | 1 | Host access enable, active low |
| host_sel | input | 1 | 0 selects the mailboxes, 1 selects the data port |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned by the last status read |
| data_wr_stb | output | 1 | One-clock data write request |
| data_rd_stb | output | 1 | One-clock data read request |
| abort_pulse | output | 1 | One-clock transfer abort |
| brk_set | input | 1 | Break control from the sub-controller |
| cmd_irq | output | 1 | Command-waiting interrupt |
| sub_cmd_pop | input | 1 | Sub-controller removes the head command byte |
| sub_cmd_data | output | 8 | Head of the command queue |
| sub_stat_push | input | 1 | Sub-controller loads a status byte |
| sub_stat_data | input | 8 | Status byte to load |
| stat_avail_n | output | 1 | Low while status bytes are waiting |

## Verification
A pointer or count that drifts in either queue shows up at the ports within one drain. The sub-controller then receives a byte out of order, or `cmd_irq` drops too early or stays up after the last pop. An empty-queue read that returns a non-zero byte would also reveal it. A decoder that mixes up the four operations changes the wrong queue or the wrong strobe on the third clock after the strobe falls. An edge detector that fires again on a held strobe gives a second queue entry, and that entry is visible on the next pop. A missing flush or a longer abort pulse is visible on `stat_avail_n` and the abort counter in the same cycle.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_CMD_WR  = 3'd1,
        OP_STAT_RD = 3'd2,
        OP_DATA_WR = 3'd3,
        OP_DATA_RD = 3'd4
    } host_op_e;
endpackage

// File: rtl/hostmbx_sync.sv
module hostmbx_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dsync,
    output logic [W-1:0] dprev
);
    typedef struct packed {
        logic [STAGES:0][W-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i <= STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dsync = st_q.pipe[STAGES-1];
    assign dprev = st_q.pipe[STAGES];
endmodule

// File: rtl/hostmbx_decode.sv
module hostmbx_decode
    import hostmbx_pkg::*;
(
    input  logic     en_n,
    input  logic     en_n_prev,
    input  logic     sel,
    input  logic     sel_prev,
    input  logic     rd_n,
    input  logic     rd_n_prev,
    input  logic     wr_n,
    input  logic     wr_n_prev,
    output host_op_e op
);
    logic ctl_ok;
    logic wr_edge;
    logic rd_edge;

    always_comb begin
        ctl_ok  = !en_n && !en_n_prev && (sel == sel_prev);
        wr_edge = wr_n_prev && !wr_n && rd_n;
        rd_edge = rd_n_prev && !rd_n && wr_n;
        op      = OP_NONE;
        if (ctl_ok) begin
            if (wr_edge) begin
                op = sel ? OP_DATA_WR : OP_CMD_WR;
            end else if (rd_edge) begin
                op = sel ? OP_DATA_RD : OP_STAT_RD;
            end
        end
    end
endmodule

// File: rtl/hostmbx_fifo.sv
module hostmbx_fifo #(
    parameter int unsigned DEPTH = 12,
    parameter int unsigned WIDTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  logic                           flush,
    input  logic [WIDTH-1:0]               wdata,
    output logic [WIDTH-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               rd_ptr;
        logic [PW-1:0]               wr_ptr;
        logic [CW-1:0]               cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic push_ok;
    logic pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr_ptr] = wdata;
                st_d.wr_ptr = (st_q.wr_ptr == PW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                st_d.rd_ptr = (st_q.rd_ptr == PW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (pop_ok && !push_ok) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd_ptr];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/hostmbx_top.sv
module hostmbx_top
    import hostmbx_pkg::*;
#(
    parameter int unsigned DEPTH       = 12,
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_en_n,
    input  logic             host_sel,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    output logic             data_wr_stb,
    output logic             data_rd_stb,
    output logic             abort_pulse,
    input  logic             brk_set,
    output logic             cmd_irq,
    input  logic             sub_cmd_pop,
    output logic [WIDTH-1:0] sub_cmd_data,
    input  logic             sub_stat_push,
    input  logic [WIDTH-1:0] sub_stat_data,
    output logic             stat_avail_n
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] rdata;
        logic             irq;
        logic             abort;
        logic             dwr;
        logic             drd;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [3:0]       ctl_sync;
    logic [3:0]       ctl_prev;
    host_op_e         op;
    logic             cmd_push;
    logic             cmd_full;
    logic             cmd_empty;
    logic [CW-1:0]    cmd_count;
    logic             stat_pop;
    logic             stat_flush;
    logic [WIDTH-1:0] stat_head;
    logic [CW-1:0]    stat_count;
    logic             stat_empty;
    logic             stat_full;

    hostmbx_sync #(
        .W      (4),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({host_en_n, host_sel, host_rd_n, host_wr_n}),
        .dsync (ctl_sync),
        .dprev (ctl_prev)
    );

    hostmbx_decode decode_i (
        .en_n      (ctl_sync[3]),
        .en_n_prev (ctl_prev[3]),
        .sel       (ctl_sync[2]),
        .sel_prev  (ctl_prev[2]),
        .rd_n      (ctl_sync[1]),
        .rd_n_prev (ctl_prev[1]),
        .wr_n      (ctl_sync[0]),
        .wr_n_prev (ctl_prev[0]),
        .op        (op)
    );

    assign cmd_push   = (op == OP_CMD_WR);
    assign stat_pop   = (op == OP_STAT_RD);
    assign stat_flush = cmd_push && brk_set;

    hostmbx_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) cmd_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_push),
        .pop   (sub_cmd_pop),
        .flush (1'b0),
        .wdata (host_wdata),
        .head  (sub_cmd_data),
        .count (cmd_count),
        .empty (cmd_empty),
        .full  (cmd_full)
    );

    hostmbx_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) stat_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sub_stat_push),
        .pop   (stat_pop),
        .flush (stat_flush),
        .wdata (sub_stat_data),
        .head  (stat_head),
        .count (stat_count),
        .empty (stat_empty),
        .full  (stat_full)
    );

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        st_d.dwr   = 1'b0;
        st_d.drd   = 1'b0;
        case (op)
            OP_CMD_WR:  st_d.abort = brk_set;
            OP_STAT_RD: st_d.rdata = stat_empty ? '0 : stat_head;
            OP_DATA_WR: st_d.dwr   = 1'b1;
            OP_DATA_RD: st_d.drd   = 1'b1;
            default:    ;
        endcase
        if (cmd_push && !cmd_full) begin
            st_d.irq = 1'b1;
        end else if (sub_cmd_pop && (cmd_count == CW'(1))) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata   = st_q.rdata;
    assign cmd_irq      = st_q.irq;
    assign abort_pulse  = st_q.abort;
    assign data_wr_stb  = st_q.dwr;
    assign data_rd_stb  = st_q.drd;
    assign stat_avail_n = (stat_count == '0);

    logic unused_ok;
    assign unused_ok = &{1'b0, cmd_empty, stat_full};
endmodule

// File: rtl/hostmbx_chk.sv
module hostmbx_chk
    import hostmbx_pkg::*;
#(
    parameter int unsigned DEPTH = 12,
    parameter int unsigned WIDTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input host_op_e                   op,
    input logic [$clog2(DEPTH+1)-1:0] cmd_count,
    input logic                       stat_empty,
    input logic                       cmd_irq,
    input logic                       sub_cmd_pop,
    input logic [WIDTH-1:0]           host_rdata,
    input logic                       abort_pulse,
    input logic                       stat_avail_n,
    input logic                       data_wr_stb,
    input logic                       data_rd_stb
);
    AST_CMD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_count <= DEPTH); // R5
    AST_IRQ_TRACKS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq == (cmd_count != '0)); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_irq && !sub_cmd_pop) |=> cmd_irq); // R6
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STAT_RD && stat_empty) |=> (host_rdata == '0)); // R7
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R9
    AST_ABORT_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> stat_avail_n); // R9
    AST_DATA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_wr_stb, data_rd_stb})); // R3
    AST_DATA_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_stb |=> !data_wr_stb); // R10
    AST_DATA_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_stb |=> !data_rd_stb); // R10
endmodule

bind hostmbx_top hostmbx_chk #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op           (op),
    .cmd_count    (cmd_count),
    .stat_empty   (stat_empty),
    .cmd_irq      (cmd_irq),
    .sub_cmd_pop  (sub_cmd_pop),
    .host_rdata   (host_rdata),
    .abort_pulse  (abort_pulse),
    .stat_avail_n (stat_avail_n),
    .data_wr_stb  (data_wr_stb),
    .data_rd_stb  (data_rd_stb)
);

// File: tb/hostmbx_tb.sv
`timescale 1ns/1ps
module hostmbx_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_en_n = 1'b1;
    logic       host_sel = 1'b0;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       data_wr_stb;
    logic       data_rd_stb;
    logic       abort_pulse;
    logic       brk_set = 1'b0;
    logic       cmd_irq;
    logic       sub_cmd_pop = 1'b0;
    logic [7:0] sub_cmd_data;
    logic       sub_stat_push = 1'b0;
    logic [7:0] sub_stat_data = 8'h00;
    logic       stat_avail_n;

    int total = 0;
    int bad = 0;
    int dwr_cnt = 0;
    int drd_cnt = 0;
    int abort_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hostmbx_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_en_n    (host_en_n),
        .host_sel     (host_sel),
        .host_rd_n    (host_rd_n),
        .host_wr_n    (host_wr_n),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .data_wr_stb  (data_wr_stb),
        .data_rd_stb  (data_rd_stb),
        .abort_pulse  (abort_pulse),
        .brk_set      (brk_set),
        .cmd_irq      (cmd_irq),
        .sub_cmd_pop  (sub_cmd_pop),
        .sub_cmd_data (sub_cmd_data),
        .sub_stat_push(sub_stat_push),
        .sub_stat_data(sub_stat_data),
        .stat_avail_n (stat_avail_n)
    );

    always @(negedge clk) begin
        if (data_wr_stb) dwr_cnt++;
        if (data_rd_stb) drd_cnt++;
        if (abort_pulse) abort_cnt++;
    end

    // kind: 0 command write, 1 status read, 2 data write, 3 data read
    localparam logic [17:0] VEC [8] = '{
        {2'd0, 8'h11, 8'h00},
        {2'd0, 8'h22, 8'h00},
        {2'd2, 8'h33, 8'h00},
        {2'd3, 8'h00, 8'h00},
        {2'd1, 8'h00, 8'hA1},
        {2'd1, 8'h00, 8'hA2},
        {2'd1, 8'h00, 8'hA3},
        {2'd1, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_op(input logic en_v, input logic sel_v, input logic rd_v,
                           input logic [7:0] d, input int hold);
        @(negedge clk);
        host_en_n  = en_v;
        host_sel   = sel_v;
        host_wdata = d;
        @(negedge clk);
        if (rd_v) host_rd_n = 1'b0;
        else      host_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        host_en_n = 1'b1;
    endtask

    task automatic sub_push(input logic [7:0] d);
        @(negedge clk);
        sub_stat_push = 1'b1;
        sub_stat_data = d;
        @(negedge clk);
        sub_stat_push = 1'b0;
    endtask

    task automatic sub_pop();
        @(negedge clk);
        sub_cmd_pop = 1'b1;
        @(negedge clk);
        sub_cmd_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d0;
        int r0;
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_irq == 0 && stat_avail_n == 1 && abort_pulse == 0, "R11 flags",
              {cmd_irq, stat_avail_n, abort_pulse}, 3'b010);
        check(host_rdata == 8'h00 && !data_wr_stb && !data_rd_stb, "R11 rdata",
              host_rdata, 0);

        sub_push(8'hA1);
        sub_push(8'hA2);
        sub_push(8'hA3);
        check(stat_avail_n == 0, "R8 avail low", stat_avail_n, 0);

        // vector table walk: R1 R2 R3 R7
        for (int i = 0; i < 8; i++) begin
            d0 = dwr_cnt;
            r0 = drd_cnt;
            host_op(1'b0, VEC[i][17], (VEC[i][16:16] == 1'b1), VEC[i][15:8], 4);
            case (VEC[i][17:16])
                2'd1: check(host_rdata == VEC[i][7:0], "R2/R7 status read",
                            host_rdata, VEC[i][7:0]);
                2'd2: check(dwr_cnt == d0 + 1 && drd_cnt == r0, "R3 data write strobe",
                            dwr_cnt - d0, 1);
                2'd3: check(drd_cnt == r0 + 1 && dwr_cnt == d0, "R3 data read strobe",
                            drd_cnt - r0, 1);
                default: check(cmd_irq == 1, "R6 irq after write", cmd_irq, 1);
            endcase
        end
        check(stat_avail_n == 1, "R8 avail high when empty", stat_avail_n, 1);
        check(host_rdata == 8'h00, "R7 empty read zero", host_rdata, 0);

        check(sub_cmd_data == 8'h11, "R1 first command", sub_cmd_data, 8'h11);
        sub_pop();
        check(cmd_irq == 1, "R6 irq held", cmd_irq, 1);
        check(sub_cmd_data == 8'h22, "R1 second command", sub_cmd_data, 8'h22);
        sub_pop();
        check(cmd_irq == 0, "R6 irq cleared on drain", cmd_irq, 0);

        // R4: disabled access
        d0 = dwr_cnt;
        host_op(1'b1, 1'b0, 1'b0, 8'h99, 4);
        host_op(1'b1, 1'b1, 1'b0, 8'h98, 4);
        check(cmd_irq == 0 && dwr_cnt == d0, "R4 disabled ignored", cmd_irq, 0);

        // R10: long strobe gives one push
        host_op(1'b0, 1'b0, 1'b0, 8'h5C, 20);
        check(cmd_irq == 1 && sub_cmd_data == 8'h5C, "R10 long strobe push",
              sub_cmd_data, 8'h5C);
        sub_pop();
        check(cmd_irq == 0, "R10 single push", cmd_irq, 0);

        // R5: fill command queue, thirteenth dropped
        for (int i = 0; i < 13; i++) host_op(1'b0, 1'b0, 1'b0, 8'h40 + 8'(i), 4);
        for (int i = 0; i < 12; i++) begin
            check(sub_cmd_data == 8'h40 + 8'(i), "R5 order after overflow",
                  sub_cmd_data, 8'h40 + i);
            sub_pop();
        end
        check(cmd_irq == 0, "R5 overflow dropped", cmd_irq, 0);

        // R8: status queue full
        for (int i = 0; i < 13; i++) sub_push(8'hB0 + 8'(i));
        for (int i = 0; i < 12; i++) begin
            host_op(1'b0, 1'b0, 1'b1, 8'h00, 4);
            check(host_rdata == 8'hB0 + 8'(i), "R8 status order", host_rdata, 8'hB0 + i);
        end
        check(stat_avail_n == 1, "R8 extra push dropped", stat_avail_n, 1);
        host_op(1'b0, 1'b0, 1'b1, 8'h00, 4);
        check(host_rdata == 8'h00, "R7 empty after full drain", host_rdata, 0);

        // R9: break abort
        sub_push(8'hC1);
        sub_push(8'hC2);
        a0 = abort_cnt;
        brk_set = 1'b1;
        host_op(1'b0, 1'b0, 1'b0, 8'h77, 4);
        brk_set = 1'b0;
        check(abort_cnt == a0 + 1, "R9 one abort pulse", abort_cnt - a0, 1);
        check(stat_avail_n == 1, "R9 status flushed", stat_avail_n, 1);
        check(cmd_irq == 1 && sub_cmd_data == 8'h77, "R9 command kept", sub_cmd_data, 8'h77);
        host_op(1'b0, 1'b0, 1'b0, 8'h78, 4);
        check(abort_cnt == a0 + 1, "R9 no abort without break", abort_cnt - a0, 1);
        sub_pop();
        check(sub_cmd_data == 8'h78 && cmd_irq == 1, "R9 queue intact", sub_cmd_data, 8'h78);
        sub_pop();
        check(cmd_irq == 0, "R6 drained", cmd_irq, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule